// File: doc/BRIEF.md
# Prediction-Guided Voltage and Frequency Margin Controller

This block steers a pipeline's operating point by emitting a supply-voltage code and a clock-frequency code. It does not hold a fixed worst-case guard band. Instead it keeps stepping toward tighter operation. Each step is judged by a verdict from timing sensors that sit on flip-flops with adaptable timing. When the sensors predict a timing error, the block backs off by a single step to restore a narrow margin.

Two goals are supported. In power mode the voltage code walks downward while no error is predicted. Once the voltage sits at its floor, the frequency code walks downward instead. A predicted error lifts the voltage by one step. In performance mode the frequency code climbs while no error is predicted, and a predicted error drops it by one step.

After every change to a code, a programmable settle interval follows. During that interval the sensors are switched off and the codes are frozen. A prediction that still arrives during the interval is remembered. It is acted on as soon as monitoring resumes.

Top module: `margin_seek_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the voltage code loads `v_max`, the frequency code loads `f_min`, and the controller sits in monitoring with `sens_en` = 1.
- R2: Power mode (`perf_mode` = 0), no error verdict, and voltage code above `v_min`: the voltage code drops by `v_step` at the verdict edge, clamped at `v_min`. The frequency code is unchanged.
- R3: Power mode, no error verdict, and voltage code equal to `v_min`: the frequency code drops by `f_step`, clamped at `f_min`. The voltage code is unchanged.
- R4: Power mode with an error verdict: the voltage code rises by `v_step`, clamped at `v_max`. The frequency code is unchanged.
- R5: Performance mode (`perf_mode` = 1) with no error verdict: the frequency code rises by `f_step`, clamped at `f_max`. The voltage code never moves in performance mode.
- R6: Performance mode with an error verdict: the frequency code drops by `f_step`, clamped at `f_min`.
- R7: Neither code ever leaves its [min, max] range or wraps. A verdict that changes neither code starts no settle interval.
- R8: The verdict is the OR of all bits of `pred_err`, taken only at edges where `sens_valid` = 1 while monitoring. With `sens_valid` = 0, no flag pattern moves a code.
- R9: After a code change, `sens_en` is 0 for exactly `settle_cycles` cycles and both codes stay frozen. With `settle_cycles` = 0, monitoring continues at once.
- R10: An error flagged with `sens_valid` = 1 during settle changes nothing at once. It is latched and applied as an error verdict at the first monitoring edge.
- R11: At most one of the two codes changes at any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| perf_mode | input | 1 | 1 = performance goal, 0 = power goal |
| pred_err | input | NUM_SENS | Per-sensor timing-error prediction flags |
| sens_valid | input | 1 | Flags are meaningful in this cycle |
| v_step | input | STEP_W | Voltage code step size |
| f_step | input | STEP_W | Frequency code step size |
| v_min | input | VW | Lowest allowed voltage code |
| v_max | input | VW | Highest allowed voltage code, also the reset value |
| f_min | input | FW | Lowest allowed frequency code, also the reset value |
| f_max | input | FW | Highest allowed frequency code |
| settle_cycles | input | SETTLE_W | Idle cycles after each code change |
| v_code | output | VW | Supply-voltage code |
| f_code | output | FW | Clock-frequency code |
| sens_en | output | 1 | Sensor enable, high while monitoring |

## Verification
The properties assume that the limit inputs are ordered, with min not above max. They also assume that a limit is never moved past the code it bounds while the block runs, so that a tightened limit cannot leave a code outside its range. The stimulus sets every limit before reset is released. Later it raises only `v_min`, and only to a value at or below the current voltage code. Step sizes, the mode and the settle length change only between verdicts, while the controller is monitoring.

// File: rtl/msc_pkg.sv
package msc_pkg;
   typedef enum logic {
      ST_MON    = 1'b0,
      ST_SETTLE = 1'b1
   } msc_state_e;

   typedef struct packed {
      logic en;
      logic up;
   } msc_move_t;
endpackage

// File: rtl/msc_err_merge.sv
module msc_err_merge #(
   parameter int NUM_SENS = 8
) (
   input  logic [NUM_SENS-1:0] flags,
   input  logic                strobe,
   output logic                hit
);
   logic any_flag;

   generate
      if (NUM_SENS == 1) begin : g_single
         assign any_flag = flags[0];
      end else begin : g_multi
         assign any_flag = |flags;
      end
   endgenerate

   assign hit = strobe & any_flag;
endmodule

// File: rtl/msc_sat_step.sv
module msc_sat_step #(
   parameter int W      = 8,
   parameter int STEP_W = 4
) (
   input  logic [W-1:0]      cur,
   input  logic [STEP_W-1:0] step,
   input  logic [W-1:0]      lo,
   input  logic [W-1:0]      hi,
   input  logic              en,
   input  logic              up,
   output logic [W-1:0]      nxt,
   output logic              moved
);
   localparam int XW = W + 1;

   logic [XW-1:0] step_x;
   logic [XW-1:0] sum_x;
   logic [XW-1:0] dif_x;
   logic          borrow;

   assign step_x = {{(XW-STEP_W){1'b0}}, step};
   assign sum_x  = {1'b0, cur} + step_x;
   assign borrow = ({1'b0, cur} < step_x);
   assign dif_x  = {1'b0, cur} - step_x;

   always_comb begin
      nxt = cur;
      if (en) begin
         if (up) begin
            nxt = (sum_x > {1'b0, hi}) ? hi : sum_x[W-1:0];
         end else begin
            nxt = (borrow || (dif_x < {1'b0, lo})) ? lo : dif_x[W-1:0];
         end
      end
   end

   assign moved = (nxt != cur);
endmodule

// File: rtl/msc_settle_timer.sv
module msc_settle_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] load,
   output logic          busy
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/margin_seek_ctrl.sv
module margin_seek_ctrl
   import msc_pkg::*;
#(
   parameter int NUM_SENS = 8,
   parameter int VW       = 8,
   parameter int FW       = 8,
   parameter int STEP_W   = 4,
   parameter int SETTLE_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                perf_mode,
   input  logic [NUM_SENS-1:0] pred_err,
   input  logic                sens_valid,
   input  logic [STEP_W-1:0]   v_step,
   input  logic [STEP_W-1:0]   f_step,
   input  logic [VW-1:0]       v_min,
   input  logic [VW-1:0]       v_max,
   input  logic [FW-1:0]       f_min,
   input  logic [FW-1:0]       f_max,
   input  logic [SETTLE_W-1:0] settle_cycles,
   output logic [VW-1:0]       v_code,
   output logic [FW-1:0]       f_code,
   output logic                sens_en
);
   generate
      if (NUM_SENS < 1) begin : g_bad_sens
         $error("NUM_SENS must be at least 1");
      end
      if (STEP_W < 1 || STEP_W > VW || STEP_W > FW) begin : g_bad_step
         $error("STEP_W must lie in 1..min(VW,FW)");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("SETTLE_W must be at least 1");
      end
   endgenerate

   msc_state_e     state;
   logic           busy;
   logic           live_hit;
   logic           pend_q;
   logic           decide;
   logic           err_now;
   logic           changed;
   msc_move_t      v_mv, f_mv;
   logic [VW-1:0]  v_q, v_nxt;
   logic [FW-1:0]  f_q, f_nxt;
   logic           v_moved, f_moved;

   msc_err_merge #(.NUM_SENS(NUM_SENS)) u_merge (
      .flags  (pred_err),
      .strobe (sens_valid),
      .hit    (live_hit)
   );

   assign state   = busy ? ST_SETTLE : ST_MON;
   assign decide  = (state == ST_MON) && (sens_valid || pend_q);
   assign err_now = pend_q || live_hit;

   always_comb begin
      v_mv = '{en: 1'b0, up: 1'b0};
      f_mv = '{en: 1'b0, up: 1'b0};
      if (decide) begin
         if (perf_mode) begin
            f_mv = '{en: 1'b1, up: !err_now};
         end else if (err_now) begin
            v_mv = '{en: 1'b1, up: 1'b1};
         end else if (v_q > v_min) begin
            v_mv = '{en: 1'b1, up: 1'b0};
         end else begin
            f_mv = '{en: 1'b1, up: 1'b0};
         end
      end
   end

   msc_sat_step #(.W(VW), .STEP_W(STEP_W)) u_vstep (
      .cur   (v_q),
      .step  (v_step),
      .lo    (v_min),
      .hi    (v_max),
      .en    (v_mv.en),
      .up    (v_mv.up),
      .nxt   (v_nxt),
      .moved (v_moved)
   );

   msc_sat_step #(.W(FW), .STEP_W(STEP_W)) u_fstep (
      .cur   (f_q),
      .step  (f_step),
      .lo    (f_min),
      .hi    (f_max),
      .en    (f_mv.en),
      .up    (f_mv.up),
      .nxt   (f_nxt),
      .moved (f_moved)
   );

   assign changed = v_moved || f_moved;

   msc_settle_timer #(.CW(SETTLE_W)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .start (changed),
      .load  (settle_cycles),
      .busy  (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= v_max;
         f_q    <= f_min;
         pend_q <= 1'b0;
      end else begin
         v_q <= v_nxt;
         f_q <= f_nxt;
         if (decide) begin
            pend_q <= 1'b0;
         end else if (state == ST_SETTLE && live_hit) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign v_code  = v_q;
   assign f_code  = f_q;
   assign sens_en = (state == ST_MON);
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
   parameter int NUM_SENS = 8,
   parameter int VW       = 8,
   parameter int FW       = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                perf_mode,
   input logic [NUM_SENS-1:0] pred_err,
   input logic                sens_valid,
   input logic [VW-1:0]       v_min,
   input logic [VW-1:0]       v_max,
   input logic [FW-1:0]       f_min,
   input logic [FW-1:0]       f_max,
   input logic [VW-1:0]       v_code,
   input logic [FW-1:0]       f_code,
   input logic                sens_en,
   input logic                pend_q
);
   AST_CODES_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (v_code >= v_min) && (v_code <= v_max) && (f_code >= f_min) && (f_code <= f_max)); // R7

   AST_ONE_CODE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(v_code) || $stable(f_code)); // R11

   AST_PERF_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
      $past(perf_mode) |-> $stable(v_code)); // R5

   AST_FROZEN_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sens_en |=> ($stable(v_code) && $stable(f_code))); // R9

   AST_NO_STROBE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_en && !sens_valid && !pend_q) |=> ($stable(v_code) && $stable(f_code))); // R8

   AST_POWER_ERR_RAISES_V: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_en && sens_valid && (|pred_err) && !perf_mode && (v_code < v_max))
      |=> (v_code > $past(v_code))); // R4
endmodule

bind margin_seek_ctrl msc_checker #(
   .NUM_SENS (NUM_SENS),
   .VW       (VW),
   .FW       (FW)
) u_msc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .perf_mode  (perf_mode),
   .pred_err   (pred_err),
   .sens_valid (sens_valid),
   .v_min      (v_min),
   .v_max      (v_max),
   .f_min      (f_min),
   .f_max      (f_max),
   .v_code     (v_code),
   .f_code     (f_code),
   .sens_en    (sens_en),
   .pend_q     (pend_q)
);

// File: tb/tb_margin_seek_ctrl.sv
module tb_margin_seek_ctrl;
   localparam int NS = 8;
   localparam int VW = 8;
   localparam int FW = 8;
   localparam int SW = 4;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          perf_mode = 1'b0;
   logic [NS-1:0] pred_err = '0;
   logic          sens_valid = 1'b0;
   logic [SW-1:0] v_step = 4'd5;
   logic [SW-1:0] f_step = 4'd6;
   logic [VW-1:0] v_min = 8'd150;
   logic [VW-1:0] v_max = 8'd200;
   logic [FW-1:0] f_min = 8'd40;
   logic [FW-1:0] f_max = 8'd60;
   logic [CW-1:0] settle_cycles = 6'd2;
   logic [VW-1:0] v_code;
   logic [FW-1:0] f_code;
   logic          sens_en;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   margin_seek_ctrl #(.NUM_SENS(NS), .VW(VW), .FW(FW), .STEP_W(SW), .SETTLE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .perf_mode(perf_mode), .pred_err(pred_err),
      .sens_valid(sens_valid), .v_step(v_step), .f_step(f_step),
      .v_min(v_min), .v_max(v_max), .f_min(f_min), .f_max(f_max),
      .settle_cycles(settle_cycles), .v_code(v_code), .f_code(f_code), .sens_en(sens_en)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic verdict(input logic [NS-1:0] flags);
      @(negedge clk);
      sens_valid = 1'b1;
      pred_err   = flags;
      @(negedge clk);
      sens_valid = 1'b0;
      pred_err   = '0;
   endtask

   task automatic wait_mon();
      while (!sens_en) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 v_code", v_code, 200);
      check("R1 f_code", f_code, 40);
      check("R1 sens_en", sens_en, 1);
   endtask

   task automatic t_perf_climb();
      perf_mode = 1'b1;
      verdict(8'h00);
      check("R5 f up", f_code, 46);
      check("R5 v held", v_code, 200);
      check("R9 sens off", sens_en, 0);
      wait_mon(); verdict(8'h00); check("R5 f up", f_code, 52);
      wait_mon(); verdict(8'h00); check("R5 f up", f_code, 58);
      wait_mon(); verdict(8'h00); check("R7 f clamp max", f_code, 60);
      wait_mon(); verdict(8'h00);
      check("R7 f stays max", f_code, 60);
      check("R7 no settle", sens_en, 1);
   endtask

   task automatic t_perf_error();
      wait_mon(); verdict(8'h80);
      check("R6 f down", f_code, 54);
      check("R6 v held", v_code, 200);
   endtask

   task automatic t_power_basic();
      wait_mon();
      perf_mode = 1'b0;
      verdict(8'h00);
      check("R2 v down", v_code, 195);
      check("R2 f held", f_code, 54);
      wait_mon(); verdict(8'h01);
      check("R4 v up", v_code, 200);
      check("R8 single bit", f_code, 54);
   endtask

   task automatic t_strobe_low();
      wait_mon();
      @(negedge clk);
      pred_err = 8'hFF;
      repeat (3) @(negedge clk);
      check("R8 v ignored", v_code, 200);
      check("R8 f ignored", f_code, 54);
      check("R8 still monitoring", sens_en, 1);
      pred_err = '0;
   endtask

   task automatic t_floor();
      v_min = 8'd190;
      wait_mon(); verdict(8'h00); check("R2 v down", v_code, 195);
      wait_mon(); verdict(8'h00); check("R2 v at floor", v_code, 190);
      wait_mon(); verdict(8'h00);
      check("R3 f down", f_code, 48);
      check("R3 v held", v_code, 190);
      wait_mon(); verdict(8'h00); check("R3 f down", f_code, 42);
      wait_mon(); verdict(8'h00); check("R7 f clamp min", f_code, 40);
      wait_mon(); verdict(8'h00);
      check("R7 f stays min", f_code, 40);
      check("R7 no settle", sens_en, 1);
   endtask

   task automatic t_settle_len();
      int low;
      settle_cycles = 6'd3;
      wait_mon(); verdict(8'h20);
      check("R4 v up", v_code, 195);
      low = 0;
      while (!sens_en && low < 20) begin
         low++;
         @(negedge clk);
      end
      check("R9 settle length", low, 3);
   endtask

   task automatic t_latch();
      settle_cycles = 6'd4;
      wait_mon(); verdict(8'h00);
      check("R2 v down", v_code, 190);
      verdict(8'h04);
      check("R10 no action in settle", v_code, 190);
      wait_mon();
      check("R10 still before mon", v_code, 190);
      @(negedge clk);
      check("R10 latched error applied", v_code, 195);
      check("R10 settle again", sens_en, 0);
   endtask

   task automatic t_zero_settle();
      wait_mon();
      settle_cycles = 6'd0;
      verdict(8'h00);
      check("R9 zero settle move", v_code, 190);
      check("R9 zero settle mon", sens_en, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_perf_climb();
      t_perf_error();
      t_power_basic();
      t_strobe_low();
      t_floor();
      t_settle_len();
      t_latch();
      t_zero_settle();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule